// File: doc/BRIEF.md
# NAND Hamming ECC Generator

This block computes the three-byte single-error-correcting parity code used to protect NAND pages. It works on a data block of either 256 or 512 bytes. Bytes stream in one per cycle under a valid strobe, and a start-of-block flag marks the first byte. The byte position is tracked inside the block.

For every bit of the byte address, the block keeps two one-bit line parities: one for the bytes where that address bit is 0, and one for the bytes where it is 1. It also keeps a running XOR of all bytes, from which six column parities are taken. Every stored parity bit is inverted, so it reads 1 when its covered bits hold an even number of ones.

The block size and the order of the two line-parity bytes are captured when a block starts. One cycle after the final byte, the code appears on `code_o` together with a one-cycle `done_o` pulse. The block is then ready for the next start.

Top module: `nand_ecc_gen`

## Requirements
- R1: `size_sel_i` = 2'b01 selects a 512-byte block. Every other value selects 256 bytes. `done_o` rises only after exactly that many accepted bytes.
- R2: Line parity rp(2k) is the parity of all bytes whose address bit k is 0, and rp(2k+1) covers the bytes whose address bit k is 1. The low-line byte carries rp7..rp0 at bits 7..0. The high-line byte carries rp15..rp8 at bits 7..0.
- R3: Every code bit except the 256-byte filler bits is an inverted parity. An all-zero block therefore yields 24'hFFFFFF in 256-byte mode.
- R4: Let P be the XOR of all bytes. Code byte 2 (`code_o[23:16]`) bits 7..2 hold the inverted parity of P masked with 0xF0, 0x0F, 0xCC, 0x33, 0xAA and 0x55, in that order.
- R5: In 256-byte mode, code byte 2 bits 1:0 are both 1.
- R6: In 512-byte mode, code byte 2 bit 1 is inverted rp17 and bit 0 is inverted rp16. These use address bit 8.
- R7: Code byte 0 is `code_o[7:0]` and code byte 1 is `code_o[15:8]`. With `swap_i` = 1, code byte 0 is the low-line byte and code byte 1 is the high-line byte. With `swap_i` = 0 the two are exchanged.
- R8: `done_o` is a one-cycle pulse in the cycle after the final byte is accepted. `code_o` is valid then and holds until the first byte of the next block is accepted.
- R9: `size_sel_i` and `swap_i` are sampled only with the start byte. Changes later in the block have no effect.
- R10: Cycles with `valid_i` low are skipped. Valid bytes without a start flag while no block is open are ignored and leave `code_o` unchanged.
- R11: A start byte in the middle of a block discards the partial block and begins a new one at byte index 0.
- R12: Reset clears the accumulators, the byte counter and `done_o`. After reset `code_o` reads 24'hFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Byte on `data_i` is valid this cycle |
| sob_i | input | 1 | Qualified by `valid_i`: this byte is byte 0 of a block |
| data_i | input | 8 | Data byte |
| size_sel_i | input | 2 | Block size request; 2'b01 = 512 bytes, else 256 |
| swap_i | input | 1 | Line-parity byte order select |
| code_o | output | 24 | Code bytes {byte2, byte1, byte0} |
| done_o | output | 1 | One-cycle pulse, code ready |

## Verification
The assertions assume that `sob_i` is only meaningful together with `valid_i`. They also assume that the producer never asks for more than one block to finish in consecutive cycles, which holds because a block is at least 256 bytes long. The block-length check counts accepted bytes from the last start. It therefore relies on the bench opening every block with a flagged byte.

The bench drives `sob_i` only with `valid_i` high and inserts idle gaps only between valid bytes. It holds the configuration steady except in the one test that deliberately changes it mid-block.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic big;   // 512-byte block
    logic swap;  // low-line byte goes to code byte 0
  } ecc_cfg_t;

  // inverted parity of masked value
  function automatic logic inv_par(input logic [BYTE_W-1:0] v,
                                   input logic [BYTE_W-1:0] m);
    return ~(^(v & m));
  endfunction

endpackage

// File: rtl/nand_ecc_ctrl.sv
module nand_ecc_ctrl
  import nand_ecc_pkg::*;
#(
  parameter int unsigned SMALL_LOG2 = 8,
  localparam int unsigned IDX_W = SMALL_LOG2 + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sob_i,
  input  logic [1:0]       size_sel_i,
  input  logic             swap_i,
  output logic             acc_en_o,
  output logic             acc_clr_o,
  output logic [IDX_W-1:0] idx_o,
  output ecc_cfg_t         cfg_o,
  output logic             active_o,
  output logic             done_o
);

  logic             active_q, done_q;
  logic [IDX_W-1:0] idx_q;
  ecc_cfg_t         cfg_q, cfg_now;
  logic             start, last;
  logic [IDX_W-1:0] last_idx;

  assign start     = valid_i & sob_i;
  assign acc_en_o  = valid_i & (sob_i | active_q);
  assign acc_clr_o = start;

  always_comb begin
    cfg_now = cfg_q;
    if (start) begin
      cfg_now.big  = (size_sel_i == 2'b01);  // anything else falls back to 256
      cfg_now.swap = swap_i;
    end
  end

  assign idx_o    = start ? '0 : idx_q;
  assign last_idx = {cfg_now.big, {SMALL_LOG2{1'b1}}};
  assign last     = acc_en_o & (idx_o == last_idx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      cfg_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= last;
      if (start) cfg_q <= cfg_now;
      if (acc_en_o) begin
        idx_q    <= last ? '0 : idx_o + 1'b1;
        active_q <= ~last;
      end
    end
  end

  assign cfg_o    = cfg_q;
  assign active_o = active_q;
  assign done_o   = done_q;

endmodule

// File: rtl/nand_ecc_accum.sv
module nand_ecc_accum
  import nand_ecc_pkg::*;
#(
  parameter int unsigned IDX_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              clr_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [IDX_W-1:0]  rp_even_o,
  output logic [IDX_W-1:0]  rp_odd_o,
  output logic [BYTE_W-1:0] col_o
);

  logic byte_par;
  assign byte_par = ^data_i;

  for (genvar k = 0; k < IDX_W; k++) begin : g_line
    logic ev_q, od_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ev_q <= 1'b0;
        od_q <= 1'b0;
      end else if (en_i) begin
        ev_q <= (ev_q & ~clr_i) ^ (byte_par & ~idx_i[k]);
        od_q <= (od_q & ~clr_i) ^ (byte_par &  idx_i[k]);
      end
    end
    assign rp_even_o[k] = ev_q;
    assign rp_odd_o[k]  = od_q;
  end

  logic [BYTE_W-1:0] col_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   col_q <= '0;
    else if (en_i) col_q <= (clr_i ? '0 : col_q) ^ data_i;
  end
  assign col_o = col_q;

endmodule

// File: rtl/nand_ecc_pack.sv
module nand_ecc_pack
  import nand_ecc_pkg::*;
#(
  parameter int unsigned SMALL_LOG2 = 8,
  localparam int unsigned IDX_W = SMALL_LOG2 + 1
) (
  input  logic [IDX_W-1:0]  rp_even_i,
  input  logic [IDX_W-1:0]  rp_odd_i,
  input  logic [BYTE_W-1:0] col_i,
  input  ecc_cfg_t          cfg_i,
  output logic [3*BYTE_W-1:0] code_o
);

  logic [BYTE_W-1:0] lo_line, hi_line, col_byte;

  for (genvar j = 0; j < BYTE_W/2; j++) begin : g_lines
    assign lo_line[2*j]   = ~rp_even_i[j];
    assign lo_line[2*j+1] = ~rp_odd_i[j];
    assign hi_line[2*j]   = ~rp_even_i[j+BYTE_W/2];
    assign hi_line[2*j+1] = ~rp_odd_i[j+BYTE_W/2];
  end

  assign col_byte[7] = inv_par(col_i, 8'hF0);
  assign col_byte[6] = inv_par(col_i, 8'h0F);
  assign col_byte[5] = inv_par(col_i, 8'hCC);
  assign col_byte[4] = inv_par(col_i, 8'h33);
  assign col_byte[3] = inv_par(col_i, 8'hAA);
  assign col_byte[2] = inv_par(col_i, 8'h55);
  assign col_byte[1] = cfg_i.big ? ~rp_odd_i[SMALL_LOG2]  : 1'b1;
  assign col_byte[0] = cfg_i.big ? ~rp_even_i[SMALL_LOG2] : 1'b1;

  assign code_o = cfg_i.swap ? {col_byte, hi_line, lo_line}
                             : {col_byte, lo_line, hi_line};

endmodule

// File: rtl/nand_ecc_gen.sv
module nand_ecc_gen
  import nand_ecc_pkg::*;
#(
  parameter int unsigned SMALL_LOG2 = 8,
  localparam int unsigned IDX_W = SMALL_LOG2 + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic                sob_i,
  input  logic [BYTE_W-1:0]   data_i,
  input  logic [1:0]          size_sel_i,
  input  logic                swap_i,
  output logic [3*BYTE_W-1:0] code_o,
  output logic                done_o
);

  logic             acc_en, acc_clr, active_w, cfg_big_w;
  logic [IDX_W-1:0] idx, rp_even, rp_odd;
  logic [BYTE_W-1:0] col;
  ecc_cfg_t         cfg;

  nand_ecc_ctrl #(.SMALL_LOG2(SMALL_LOG2)) u_ctrl (
    .clk_i, .rst_ni, .valid_i, .sob_i, .size_sel_i, .swap_i,
    .acc_en_o(acc_en), .acc_clr_o(acc_clr), .idx_o(idx),
    .cfg_o(cfg), .active_o(active_w), .done_o(done_o)
  );

  nand_ecc_accum #(.IDX_W(IDX_W)) u_accum (
    .clk_i, .rst_ni, .en_i(acc_en), .clr_i(acc_clr), .idx_i(idx),
    .data_i, .rp_even_o(rp_even), .rp_odd_o(rp_odd), .col_o(col)
  );

  // code is read straight from the accumulators; they hold until next start
  nand_ecc_pack #(.SMALL_LOG2(SMALL_LOG2)) u_pack (
    .rp_even_i(rp_even), .rp_odd_i(rp_odd), .col_i(col),
    .cfg_i(cfg), .code_o(code_o)
  );

  assign cfg_big_w = cfg.big;

endmodule

// File: rtl/nand_ecc_chk.sv
module nand_ecc_chk #(
  parameter int unsigned SMALL_LOG2 = 8,
  localparam int unsigned CNT_W = SMALL_LOG2 + 2
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic        sob_i,
  input logic [23:0] code_o,
  input logic        done_o,
  input logic        active_i,
  input logic        big_i
);

  logic [CNT_W-1:0] cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (valid_i && sob_i)     cnt_q <= CNT_W'(1);
    else if (valid_i && active_i)  cnt_q <= cnt_q + 1'b1;
  end

  AST_BLOCK_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cnt_q == (big_i ? CNT_W'(2 << SMALL_LOG2) : CNT_W'(1 << SMALL_LOG2))); // R1

  AST_FILL_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !big_i) |-> code_o[17:16] == 2'b11); // R5

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8

  AST_DONE_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!active_i && $past(valid_i))); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_i && !(valid_i && sob_i)) |=> ($stable(code_o) && !done_o)); // R10

endmodule

bind nand_ecc_gen nand_ecc_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .sob_i(sob_i),
  .code_o(code_o), .done_o(done_o), .active_i(active_w), .big_i(cfg_big_w)
);

// File: tb/nand_ecc_gen_tb.sv
module nand_ecc_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, sob = 1'b0, swap = 1'b0;
  logic [7:0]  data = '0;
  logic [1:0]  size_sel = '0;
  logic [23:0] code;
  logic        done;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [7:0] blk [512];

  always #4 clk = ~clk;

  nand_ecc_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .sob_i(sob), .data_i(data),
    .size_sel_i(size_sel), .swap_i(swap), .code_o(code), .done_o(done)
  );

  // {pat[2:0], seed[7:0], sel[1:0], swap, gaps, pad}
  localparam int NV = 14;
  localparam logic [15:0] VEC [NV] = '{
    {3'd0, 8'd0,   2'd0, 1'b0, 1'b0, 1'b0},
    {3'd1, 8'd0,   2'd0, 1'b0, 1'b0, 1'b0},
    {3'd2, 8'd13,  2'd0, 1'b0, 1'b0, 1'b0},
    {3'd2, 8'd13,  2'd0, 1'b1, 1'b0, 1'b0},
    {3'd3, 8'd5,   2'd0, 1'b0, 1'b0, 1'b0},
    {3'd3, 8'd77,  2'd0, 1'b1, 1'b0, 1'b0},
    {3'd4, 8'd3,   2'd1, 1'b0, 1'b0, 1'b0},
    {3'd4, 8'd9,   2'd1, 1'b1, 1'b0, 1'b0},
    {3'd3, 8'd150, 2'd1, 1'b0, 1'b0, 1'b0},
    {3'd4, 8'd21,  2'd0, 1'b0, 1'b1, 1'b0},
    {3'd2, 8'd200, 2'd1, 1'b1, 1'b1, 1'b0},
    {3'd1, 8'd0,   2'd1, 1'b0, 1'b0, 1'b0},
    {3'd4, 8'd44,  2'd2, 1'b1, 1'b0, 1'b0},
    {3'd4, 8'd45,  2'd3, 1'b0, 1'b0, 1'b0}
  };

  function automatic logic [7:0] gen(int pat, int seed, int i);
    case (pat)
      0: return 8'h00;
      1: return 8'hFF;
      2: return 8'((i + seed) & 255);
      3: return (i == seed * 3) ? 8'(1 << (seed % 8)) : 8'h00;
      default: return 8'(((i * 37 + seed * 11) ^ (i >> 3)) & 255);
    endcase
  endfunction

  function automatic void fill(int pat, int seed);
    for (int i = 0; i < 512; i++) blk[i] = gen(pat, seed, i);
  endfunction

  // expected code from the requirement text
  function automatic logic [23:0] ref_code(logic big, logic swp);
    int n = big ? 512 : 256;
    int ab = big ? 9 : 8;
    logic [17:0] rp = '0;
    logic [7:0] p = '0, lo, hi, b2;
    for (int i = 0; i < n; i++) begin
      p = p ^ blk[i];
      for (int k = 0; k < ab; k++)
        if (((i >> k) & 1) == 1) rp[2*k+1] = rp[2*k+1] ^ (^blk[i]);
        else                     rp[2*k]   = rp[2*k]   ^ (^blk[i]);
    end
    for (int j = 0; j < 8; j++) begin
      lo[j] = ~rp[j];
      hi[j] = ~rp[8+j];
    end
    b2 = {~^(p & 8'hF0), ~^(p & 8'h0F), ~^(p & 8'hCC), ~^(p & 8'h33),
          ~^(p & 8'hAA), ~^(p & 8'h55),
          big ? ~rp[17] : 1'b1, big ? ~rp[16] : 1'b1};
    return swp ? {b2, hi, lo} : {b2, lo, hi};
  endfunction

  task automatic chk(bit ok, string req, logic [23:0] act, logic [23:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %06h expected %06h", req, act, exp);
    end
  endtask

  // sends n bytes of blk; flip changes the config at byte 100
  task automatic send(int n, logic [1:0] sel, logic swp, bit gaps, bit flip);
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 7 == 3)) begin
        @(negedge clk);
        valid = 1'b0;
        sob   = 1'b0;
      end
      @(negedge clk);
      if (i == n - 1 && n >= 256) chk(done == 1'b0, "R1 early done", 24'(done), 24'd0);
      valid    = 1'b1;
      sob      = (i == 0);
      data     = blk[i];
      size_sel = (flip && i >= 100) ? ~sel : sel;
      swap     = (flip && i >= 100) ? ~swp : swp;
    end
  endtask

  task automatic finish_block(logic [23:0] exp, string tag);
    @(negedge clk);
    valid = 1'b0;
    sob   = 1'b0;
    chk(done == 1'b1, "R8 done pulse", 24'(done), 24'd1);
    chk(code == exp, tag, code, exp);
    @(negedge clk);
    chk(done == 1'b0, "R8 pulse width", 24'(done), 24'd0);
    chk(code == exp, "R8 code hold", code, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R8 watchdog: actual hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [23:0] exp, held;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(done == 1'b0, "R12 reset done", 24'(done), 24'd0);
    chk(code == 24'hFFFFFF, "R12 reset code", code, 24'hFFFFFF);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [15:0] e = VEC[v];
      logic big = (e[4:3] == 2'b01);
      fill(int'(e[15:13]), int'(e[12:5]));
      exp = ref_code(big, e[2]);
      send(big ? 512 : 256, e[4:3], e[2], e[1], 1'b0);
      finish_block(exp, big ? "R2 R3 R4 R6 R7 R1" : "R2 R3 R4 R5 R7 R1");
    end

    // R9: config change mid-block ignored
    fill(4, 99);
    exp = ref_code(1'b1, 1'b0);
    send(512, 2'b01, 1'b0, 1'b0, 1'b1);
    finish_block(exp, "R9 config held");

    // R10: unflagged bytes while idle are ignored
    held = code;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      valid = 1'b1;
      sob   = 1'b0;
      data  = 8'(i * 29 + 1);
      if (i > 0) chk(done == 1'b0 && code == held, "R10 idle ignore", code, held);
    end
    @(negedge clk);
    valid = 1'b0;
    chk(code == held, "R10 idle code", code, held);

    // R11: restart mid-block
    fill(1, 0);
    send(40, 2'b00, 1'b1, 1'b0, 1'b0);
    fill(2, 7);
    exp = ref_code(1'b0, 1'b0);
    send(256, 2'b00, 1'b0, 1'b0, 1'b0);
    finish_block(exp, "R11 restart");

    // R12: reset in the middle of a block
    fill(4, 60);
    send(100, 2'b01, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R12 mid reset done", 24'(done), 24'd0);
    chk(code == 24'hFFFFFF, "R12 mid reset code", code, 24'hFFFFFF);
    rst_n = 1'b1;
    @(negedge clk);
    exp = ref_code(1'b0, 1'b1);
    send(256, 2'b00, 1'b1, 1'b0, 1'b0);
    finish_block(exp, "R12 after reset");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule